// File: doc/BRIEF.md
# Four-Way Pairwise-Order Replacement Tracker

This block holds the recency state for a four-entry fully associative translation buffer and names which entry a refill should overwrite. The state is a 6-bit vector in which each bit records the relative age of one pair of entries. A use of any entry forces the three bits that involve that entry so that it becomes the newest. The block performs no lookup and stores no translations. It only follows uses and reports the oldest entry.

Each cycle the surrounding buffer either reports a lookup hit with the index of the entry that matched, or asks for a refill. A refill writes the entry named by the victim output, and it counts as a use of that entry. Software can also load the whole vector directly. The victim output is decoded combinationally from the current state. When the state matches none of the four victim patterns, an error flag is raised. This can only happen after software has loaded an inconsistent value.

Top module: `plru4_tracker`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `lru_state` is 6'b000000, `victim_way` is 3 and `lru_err` is 0.
- R2: A use of entry 0 clears `lru_state[5]`, `[4]` and `[3]` and leaves bits 2..0 unchanged.
- R3: A use of entry 1 sets `lru_state[5]`, clears `[2]` and `[1]`, and leaves bits 4, 3 and 0 unchanged.
- R4: A use of entry 2 sets `lru_state[4]` and `[2]`, clears `[0]`, and leaves bits 5, 3 and 1 unchanged.
- R5: A use of entry 3 sets `lru_state[3]`, `[1]` and `[0]` and leaves bits 5, 4 and 2 unchanged.
- R6: The decode tests the patterns in this order and picks the first that matches. `victim_way` is 0 when bits 5, 4 and 3 are all 1. It is 1 when bit 5 is 0 and bits 2 and 1 are 1. It is 2 when bits 4 and 2 are 0 and bit 0 is 1. It is 3 when bits 3, 1 and 0 are all 0.
- R7: When no pattern matches, `lru_err` is 1 and `victim_way` is 0. In every other state `lru_err` is 0.
- R8: `refill_vld` without `hit_vld` counts as a use of the entry named by `victim_way` in that cycle. After such a refill, that entry is no longer the victim unless `lru_err` is set.
- R9: When `hit_vld` and `refill_vld` are both high in one cycle, only the hit entry `hit_way` is used.
- R10: `wr_en` loads `wr_lru` into the state on the next edge and overrides any hit or refill in the same cycle.
- R11: In a cycle with none of `hit_vld`, `refill_vld` or `wr_en`, the state is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_vld | input | 1 | Lookup hit strobe |
| hit_way | input | 2 | Index of the entry that hit |
| refill_vld | input | 1 | Refill strobe; the victim entry is used |
| wr_en | input | 1 | Software load of the state |
| wr_lru | input | 6 | Value to load |
| victim_way | output | 2 | Entry to overwrite on the next refill |
| lru_err | output | 1 | State matches no victim pattern |
| lru_state | output | 6 | Current recency state, bit 5 first |

## Verification
The bench targets the following corner cases.

- **Bit drift on a use.** Each entry is used on top of a state of all ones and a state of all zeros. A design whose masks touched a wrong bit, or that dropped a bit it should keep, would leave a state that differs from the model.
- **Same-cycle collisions.** The bench drives a refill together with a hit on a different entry, and a software load together with a hit. A design with a wrong priority would update the wrong pair bits or lose the loaded value.
- **Inconsistent loaded state.** Loading 6'b011001 must raise the error flag and steer the victim to entry 0, and a refill from that state must use entry 0. A design that ignored the error case would point at an arbitrary entry.
- **Long random stream.** A long random mix of hits, refills and loads is compared each cycle against a model built on age relations between entries. This exposes any mismatch between the decode patterns and the update masks.

// File: rtl/plru4_pkg.sv
package plru4_pkg;

    localparam int NUM_WAYS = 4;
    localparam int WAY_W    = $clog2(NUM_WAYS);
    localparam int PAIR_W   = NUM_WAYS * (NUM_WAYS - 1) / 2;

    typedef logic [PAIR_W-1:0] lru_vec_t;
    typedef logic [WAY_W-1:0]  way_t;

    typedef struct packed {
        lru_vec_t lru;
    } plru_regs_t;

    // bits forced to one when an entry becomes the newest
    function automatic lru_vec_t use_set_mask(input int w);
        case (w)
            0:       return 6'b000000;
            1:       return 6'b100000;
            2:       return 6'b010100;
            default: return 6'b001011;
        endcase
    endfunction

    // bits forced to zero when an entry becomes the newest
    function automatic lru_vec_t use_clr_mask(input int w);
        case (w)
            0:       return 6'b111000;
            1:       return 6'b000110;
            2:       return 6'b000001;
            default: return 6'b000000;
        endcase
    endfunction

    // pair bits an entry's victim pattern depends on
    function automatic lru_vec_t victim_care(input int w);
        return use_set_mask(w) | use_clr_mask(w);
    endfunction

    // an entry is oldest when each of its pair bits is the opposite of what a use writes
    function automatic lru_vec_t victim_value(input int w);
        return use_clr_mask(w);
    endfunction

endpackage

// File: rtl/plru4_touch.sv
module plru4_touch
    import plru4_pkg::*;
(
    input  lru_vec_t cur_lru,
    input  way_t     use_way,
    output lru_vec_t new_lru
);

    lru_vec_t set_tbl [NUM_WAYS];
    lru_vec_t clr_tbl [NUM_WAYS];

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_mask
        assign set_tbl[w] = use_set_mask(w);
        assign clr_tbl[w] = use_clr_mask(w);
    end

    always_comb begin
        new_lru = (cur_lru & ~clr_tbl[use_way]) | set_tbl[use_way];
    end

endmodule

// File: rtl/plru4_victim.sv
module plru4_victim
    import plru4_pkg::*;
(
    input  lru_vec_t cur_lru,
    output way_t     victim_way,
    output logic     no_match
);

    logic [NUM_WAYS-1:0] pat_hit;

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_pat
        assign pat_hit[w] = ((cur_lru & victim_care(w)) == victim_value(w));
    end

    // lowest index wins: walk downward so the last assignment is the first match
    always_comb begin
        victim_way = '0;
        for (int w = NUM_WAYS - 1; w >= 0; w--) begin
            if (pat_hit[w]) begin
                victim_way = WAY_W'(w);
            end
        end
        no_match = ~|pat_hit;
    end

endmodule

// File: rtl/plru4_tracker.sv
module plru4_tracker
    import plru4_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hit_vld,
    input  logic [1:0]  hit_way,
    input  logic        refill_vld,
    input  logic        wr_en,
    input  logic [5:0]  wr_lru,
    output logic [1:0]  victim_way,
    output logic        lru_err,
    output logic [5:0]  lru_state
);

    plru_regs_t regs_d;
    plru_regs_t regs_q;

    way_t     use_way;
    logic     use_vld;
    lru_vec_t touched;
    way_t     vic;
    logic     vic_err;

    plru4_victim u_victim (
        .cur_lru    (regs_q.lru),
        .victim_way (vic),
        .no_match   (vic_err)
    );

    plru4_touch u_touch (
        .cur_lru (regs_q.lru),
        .use_way (use_way),
        .new_lru (touched)
    );

    always_comb begin
        use_vld = hit_vld | refill_vld;
        use_way = hit_vld ? hit_way : vic;
        regs_d  = regs_q;
        if (wr_en) begin
            regs_d.lru = wr_lru;
        end else if (use_vld) begin
            regs_d.lru = touched;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign victim_way = vic;
    assign lru_err    = vic_err;
    assign lru_state  = regs_q.lru;

endmodule

// File: rtl/plru4_tracker_chk.sv
module plru4_tracker_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       hit_vld,
    input logic [1:0] hit_way,
    input logic       refill_vld,
    input logic       wr_en,
    input logic [5:0] wr_lru,
    input logic [1:0] victim_way,
    input logic       lru_err,
    input logic [5:0] lru_state
);

    a_r2_way0_use: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_vld && hit_way == 2'd0 && !wr_en)
        |=> (lru_state[5:3] == 3'b000 && lru_state[2:0] == $past(lru_state[2:0])));

    a_r5_way3_use: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_vld && hit_way == 2'd3 && !wr_en)
        |=> (lru_state[3] && lru_state[1] && lru_state[0]
             && lru_state[5:4] == $past(lru_state[5:4])
             && lru_state[2] == $past(lru_state[2])));

    a_r7_err_steers_zero: assert property (@(posedge clk) disable iff (!rst_n)
        lru_err |-> victim_way == 2'd0);

    a_r8_refill_moves_victim: assert property (@(posedge clk) disable iff (!rst_n)
        (refill_vld && !hit_vld && !wr_en && !lru_err)
        |=> (victim_way != $past(victim_way) || lru_err));

    a_r10_sw_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> lru_state == $past(wr_lru));

    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !hit_vld && !refill_vld) |=> $stable(lru_state));

endmodule

bind plru4_tracker plru4_tracker_chk chk_i (.*);

// File: tb/plru4_tracker_tb_top.sv
module plru4_tracker_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hit_vld = 1'b0;
    logic [1:0] hit_way = 2'd0;
    logic       refill_vld = 1'b0;
    logic       wr_en = 1'b0;
    logic [5:0] wr_lru = 6'd0;
    logic [1:0] victim_way;
    logic       lru_err;
    logic [5:0] lru_state;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // reference: pair (i<j) holds 1 when entry j was used more recently than entry i
    bit [5:0] m_state;

    always #2 clk = ~clk;

    plru4_tracker dut_i (
        .clk(clk), .rst_n(rst_n), .hit_vld(hit_vld), .hit_way(hit_way),
        .refill_vld(refill_vld), .wr_en(wr_en), .wr_lru(wr_lru),
        .victim_way(victim_way), .lru_err(lru_err), .lru_state(lru_state)
    );

    function automatic int pair_pos(int a, int b);
        int lo = (a < b) ? a : b;
        int hi = (a < b) ? b : a;
        int k = 0;
        for (int i = 0; i < 4; i++) begin
            for (int j = i + 1; j < 4; j++) begin
                if (i == lo && j == hi) return 5 - k;
                k++;
            end
        end
        return 0;
    endfunction

    function automatic bit newer(bit [5:0] s, int a, int b);
        bit hi_newer = s[pair_pos(a, b)];
        return (a > b) ? hi_newer : !hi_newer;
    endfunction

    function automatic int m_victim(bit [5:0] s, output bit err);
        for (int v = 0; v < 4; v++) begin
            bit oldest = 1'b1;
            for (int k = 0; k < 4; k++) begin
                if (k != v && !newer(s, k, v)) oldest = 1'b0;
            end
            if (oldest) begin
                err = 1'b0;
                return v;
            end
        end
        err = 1'b1;
        return 0;
    endfunction

    function automatic bit [5:0] m_use(bit [5:0] s, int w);
        bit [5:0] r = s;
        for (int k = 0; k < 4; k++) begin
            if (k != w) r[pair_pos(k, w)] = (w > k);
        end
        return r;
    endfunction

    task automatic compare(string req);
        bit e_err;
        int e_vic;
        e_vic = m_victim(m_state, e_err);
        total++;
        if (lru_state !== m_state || victim_way !== 2'(e_vic) || lru_err !== e_err) begin
            bad++;
            $display("FAIL %s: actual state=%b victim=%0d err=%b expected state=%b victim=%0d err=%b",
                     req, lru_state, victim_way, lru_err, m_state, e_vic, e_err);
        end
    endtask

    task automatic step(string req, bit hv, int hw, bit rv, bit we, bit [5:0] wd);
        bit e_err;
        int e_vic;
        hit_vld = hv; hit_way = 2'(hw); refill_vld = rv; wr_en = we; wr_lru = wd;
        @(posedge clk);
        e_vic = m_victim(m_state, e_err);
        if (we)      m_state = wd;
        else if (hv) m_state = m_use(m_state, hw);
        else if (rv) m_state = m_use(m_state, e_vic);
        @(negedge clk);
        hit_vld = 1'b0; refill_vld = 1'b0; wr_en = 1'b0;
        compare(req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog R1: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        m_state = '0;
        repeat (3) @(negedge clk);
        compare("R1 during reset");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1 after release");

        // R11 idle
        step("R11 idle", 0, 0, 0, 0, 0);
        step("R11 idle", 0, 0, 0, 0, 0);

        // R2..R5 on all ones and all zeros
        for (int w = 0; w < 4; w++) begin
            string tag;
            tag = (w == 0) ? "R2" : (w == 1) ? "R3" : (w == 2) ? "R4" : "R5";
            step("R10 load ones", 0, 0, 0, 1, 6'b111111);
            step(tag, 1, w, 0, 0, 0);
            step("R10 load zeros", 0, 0, 0, 1, 6'b000000);
            step(tag, 1, w, 0, 0, 0);
        end

        // R6 canonical victim patterns
        step("R6 way0", 0, 0, 0, 1, 6'b111000);
        step("R6 way1", 0, 0, 0, 1, 6'b000110);
        step("R6 way2", 0, 0, 0, 1, 6'b000001);
        step("R6 way3", 0, 0, 0, 1, 6'b000000);

        // R8 refill stream from a clean state
        for (int i = 0; i < 6; i++) step("R8 refill", 0, 0, 1, 0, 0);

        // R7 inconsistent state, then refill from it
        step("R7 load bad", 0, 0, 0, 1, 6'b011001);
        step("R7 hold bad", 0, 0, 0, 0, 0);
        step("R7 refill in error", 0, 0, 1, 0, 0);

        // R9 hit beats refill
        step("R9 setup", 0, 0, 0, 1, 6'b000000);
        step("R9 hit+refill", 1, 1, 1, 0, 0);

        // R10 load beats hit and refill
        step("R10 load+hit", 1, 2, 1, 1, 6'b101010);
        step("R11 idle", 0, 0, 0, 0, 0);

        // random mix
        for (int i = 0; i < 3000; i++) begin
            int r = $urandom_range(0, 99);
            bit hv = (r < 50) || (r >= 90 && r < 95);
            bit rv = (r >= 50 && r < 80) || (r >= 90 && r < 95);
            bit we = (r >= 95);
            step("R6 random", hv, $urandom_range(0, 3), rv, we, 6'($urandom_range(0, 63)));
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule